// File: doc/BRIEF.md
# Byte-Stepped I2C Slave Receiver

This block is the receive side of an I2C target device, run one protocol step at a time by a host over a small register bus. The host loads the device's 7-bit bus address, turns the engine on and decides before every byte whether it will be acknowledged. The engine recognises START and STOP from synchronised copies of the SCL and SDA lines. It shifts in the address byte and the data bytes, drives the acknowledge bit, and at each meaningful bus event posts a status code and raises a single event flag.

While a byte event is pending, the engine stretches the clock by holding SCL low. The transfer therefore moves on only after the host has read the status and the received byte and cleared the flag by writing a one to it. Misplaced START or STOP conditions are reported with a dedicated error code. The engine then ignores the bus until the host writes the stop-request bit, and the same write is how the host drops out of an ongoing transfer. An interrupt line mirrors the flag when interrupts are enabled.

Top module: `i2cs_slave_rx`

## Requirements
- R1: Register map on `bus_addr`: 0 is control with bit 7 interrupt enable, bit 6 engine enable, bit 5 start request (stored only), bit 4 stop request, bit 3 event flag, bit 2 acknowledge enable and bits 1:0 reading 0. 1 is the read-only status. 2 is the read-only last received byte. 3 is the own address in bits 7:1, with bit 0 reading 0.
- R2: The event flag is set whenever a status event is posted. A control write with bit 3 at 1 clears it, and a write with bit 3 at 0 leaves it unchanged.
- R3: `irq` is 1 exactly when both the event flag and the interrupt enable are 1.
- R4: Status bits 2:0 always read 0. With no event pending the status reads F8h.
- R5: While the flag is 1 the status shows the posted code, and this code remains readable for one clock after the flag is cleared. From the following clock it reads F8h.
- R6: The first byte after a START is received MSB first. If bits 7:1 equal the own address, bit 0 is 0 and acknowledge enable is 1, the engine pulls SDA low in the ninth clock and posts 60h, and the data register holds that byte. Any other address byte gets no acknowledge and posts nothing.
- R7: While addressed, each data byte is shifted in MSB first. With acknowledge enable at 1 it is acknowledged, the engine posts 80h and the data register holds the byte.
- R8: With acknowledge enable at 0 when a data byte completes, SDA stays high in the ninth clock and the engine posts 88h. The engine then stops being addressed: later bytes are neither acknowledged nor reported until a new START.
- R9: A STOP or repeated START between data bytes of an addressed transfer posts A0h. After a repeated START the next byte is treated as an address.
- R10: A START or STOP seen after the second SCL rising edge of an address or data byte, or during its acknowledge bit, posts 00h. From then on the engine ignores the bus, acknowledging nothing, until the stop request is written.
- R11: Writing the stop request returns the engine to the not-addressed state. The stop request bit reads 0 from the next clock on and is forced to 0 while the engine is disabled.
- R12: After posting 60h, 80h or 88h the engine holds SCL low as long as the flag is 1 and releases it when the flag is cleared. It does not hold SCL for A0h or 00h.
- R13: With engine enable at 0 the engine acknowledges nothing and posts no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_low | output | 1 | Pull SCL low (clock stretch) |
| sda_low | output | 1 | Pull SDA low (acknowledge) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions rely on a bus master that honours clock stretching: it never starts another bit while SCL is held low. They also rely on SDA changing only while SCL is low, except when the master deliberately creates START or STOP. The bench's master model reads the wired-AND SCL level before every high phase and moves SDA only in the low phase. It makes exactly the misplaced START needed for the bus-error case. Host register writes happen only while the master is paused.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  localparam logic [7:0] CODE_NONE      = 8'hF8;
  localparam logic [7:0] CODE_ADDR_ACK  = 8'h60;
  localparam logic [7:0] CODE_DATA_ACK  = 8'h80;
  localparam logic [7:0] CODE_DATA_NACK = 8'h88;
  localparam logic [7:0] CODE_END       = 8'hA0;
  localparam logic [7:0] CODE_BUS_ERR   = 8'h00;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA, PH_ERR} phase_t;

  // address byte selects this device for a write transfer
  function automatic logic addr_hit(input logic [7:0] rx, input logic [6:0] own);
    return (rx[7:1] == own) && !rx[0];
  endfunction

  function automatic logic [7:0] data_code(input logic acked);
    return acked ? CODE_DATA_ACK : CODE_DATA_NACK;
  endfunction

  function automatic logic [7:0] status_word(input logic [4:0] code);
    return {code, 3'b000};
  endfunction
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cs_cond_det.sv
module i2cs_cond_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_now
);
  logic scl_s, sda_s, scl_p, sda_p;

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_scl (.clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sda (.clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  assign sda_now   = sda_s;
endmodule

// File: rtl/i2cs_rx_engine.sv
module i2cs_rx_engine
  import i2cs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       abort,
  input  logic       ack_en,
  input  logic [6:0] own_addr,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       sda_now,
  output logic       ev_valid,
  output logic [7:0] ev_code,
  output logic       ev_hold,
  output logic [7:0] rx_byte,
  output logic       sda_low
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  phase_t           ph;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       shreg;
  logic             in_ack, ack_on;
  logic             cond, in_byte, misplaced;

  assign cond      = start_det | stop_det;
  assign in_byte   = (ph == PH_ADDR) || (ph == PH_DATA);
  assign misplaced = in_byte && ((cnt > CNT_ONE) || in_ack);

  always_comb begin
    ev_valid = 1'b0;
    ev_code  = CODE_NONE;
    ev_hold  = 1'b0;
    if (en && !abort) begin
      if (cond && misplaced) begin
        ev_valid = 1'b1;
        ev_code  = CODE_BUS_ERR;
      end else if (cond && ph == PH_DATA) begin
        ev_valid = 1'b1;
        ev_code  = CODE_END;
      end else if (scl_fall && in_ack && ph == PH_ADDR) begin
        ev_valid = 1'b1;
        ev_code  = CODE_ADDR_ACK;
        ev_hold  = 1'b1;
      end else if (scl_fall && in_ack && ph == PH_DATA) begin
        ev_valid = 1'b1;
        ev_code  = data_code(ack_on);
        ev_hold  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      in_ack <= 1'b0;
      ack_on <= 1'b0;
    end else if (!en || abort) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      in_ack <= 1'b0;
      ack_on <= 1'b0;
    end else if (cond) begin
      cnt    <= '0;
      in_ack <= 1'b0;
      ack_on <= 1'b0;
      if (misplaced || ph == PH_ERR) ph <= PH_ERR;
      else                           ph <= start_det ? PH_ADDR : PH_IDLE;
    end else if (in_byte) begin
      if (scl_rise && !in_ack && cnt != CNT_FULL) begin
        shreg <= {shreg[6:0], sda_now};
        cnt   <= cnt + CNT_ONE;
      end else if (scl_fall && !in_ack && cnt == CNT_FULL) begin
        if (ph == PH_ADDR) begin
          if (addr_hit(shreg, own_addr) && ack_en) begin
            in_ack <= 1'b1;
            ack_on <= 1'b1;
          end else begin
            ph  <= PH_IDLE;
            cnt <= '0;
          end
        end else begin
          in_ack <= 1'b1;
          ack_on <= ack_en;
        end
      end else if (scl_fall && in_ack) begin
        in_ack <= 1'b0;
        ack_on <= 1'b0;
        cnt    <= '0;
        if (ph == PH_ADDR)  ph <= PH_DATA;
        else if (!ack_on)   ph <= PH_IDLE;
      end
    end

  assign rx_byte = shreg;
  assign sda_low = ack_on;
endmodule

// File: rtl/i2cs_slave_rx.sv
module i2cs_slave_rx
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_low,
  output logic       sda_low,
  output logic       irq
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_OWN  = 2'd3;

  logic       ei_q, ensi_q, sta_q, sto_q, si_q, aa_q, hold_q;
  logic [4:0] code_q;
  logic [7:0] data_q;
  logic [6:0] own_q;

  logic       scl_rise, scl_fall, start_det, stop_det, sda_now;
  logic       ev_valid, ev_hold;
  logic [7:0] ev_code, rx_byte, status_rd;
  logic       ctrl_wr, own_wr;
  wire        unused_wbits = ^bus_wdata[1:0];

  assign ctrl_wr = bus_wr && bus_addr == A_CTRL;
  assign own_wr  = bus_wr && bus_addr == A_OWN;

  i2cs_cond_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_now(sda_now)
  );

  i2cs_rx_engine u_eng (
    .clk(clk), .rst_n(rst_n), .en(ensi_q), .abort(sto_q), .ack_en(aa_q),
    .own_addr(own_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_now(sda_now),
    .ev_valid(ev_valid), .ev_code(ev_code), .ev_hold(ev_hold),
    .rx_byte(rx_byte), .sda_low(sda_low)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ei_q   <= 1'b0;
      ensi_q <= 1'b0;
      sta_q  <= 1'b0;
      sto_q  <= 1'b0;
      aa_q   <= 1'b0;
      own_q  <= '0;
    end else begin
      // stop request acts for one clock, never while disabled
      sto_q <= ctrl_wr && bus_wdata[6] && bus_wdata[4];
      if (ctrl_wr) begin
        ei_q   <= bus_wdata[7];
        ensi_q <= bus_wdata[6];
        sta_q  <= bus_wdata[5];
        aa_q   <= bus_wdata[2];
      end
      if (own_wr) own_q <= bus_wdata[7:1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      si_q   <= 1'b0;
      hold_q <= 1'b0;
      code_q <= CODE_NONE[7:3];
      data_q <= '0;
    end else begin
      if (ev_valid)                     si_q <= 1'b1;
      else if (ctrl_wr && bus_wdata[3]) si_q <= 1'b0;

      if (ev_valid)   hold_q <= ev_hold;
      else if (sto_q) hold_q <= 1'b0;

      if (ev_valid)   code_q <= ev_code[7:3];
      else if (!si_q) code_q <= CODE_NONE[7:3];

      if (ev_valid && ev_hold) data_q <= rx_byte;
    end

  assign status_rd = status_word(code_q);
  assign scl_low   = si_q & hold_q & ensi_q;
  assign irq       = si_q & ei_q;

  always_comb
    case (bus_addr)
      A_CTRL:  bus_rdata = {ei_q, ensi_q, sta_q, sto_q, si_q, aa_q, 2'b00};
      A_STAT:  bus_rdata = status_rd;
      A_DATA:  bus_rdata = data_q;
      default: bus_rdata = {own_q, 1'b0};
    endcase
endmodule

// File: rtl/i2cs_slave_rx_chk.sv
module i2cs_slave_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       ei_q,
  input logic       si_q,
  input logic       ensi_q,
  input logic       sto_q,
  input logic [7:0] status_rd,
  input logic       scl_low,
  input logic       sda_low,
  input logic       ev_valid,
  input logic [7:0] ev_code
);
  p_irq_needs_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> si_q);
  p_irq_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ei_q |-> !irq);
  p_low_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd[2:0] == 3'b000);
  p_pending_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    si_q |-> status_rd != 8'hF8);
  p_code_lingers_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(si_q) |-> $stable(status_rd));
  p_idle_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!si_q && !$past(si_q)) |-> status_rd == 8'hF8);
  p_err_post_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_code == 8'h00) |=> (si_q && status_rd == 8'h00));
  p_sto_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ensi_q |-> !sto_q);
  p_stretch_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    scl_low |-> si_q);
  p_ack_not_stretch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sda_low |-> !scl_low);
endmodule

bind i2cs_slave_rx i2cs_slave_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .ei_q(ei_q), .si_q(si_q),
  .ensi_q(ensi_q), .sto_q(sto_q), .status_rd(status_rd),
  .scl_low(scl_low), .sda_low(sda_low), .ev_valid(ev_valid), .ev_code(ev_code)
);

// File: tb/i2cs_slave_rx_tb.sv
module i2cs_slave_rx_tb;
  localparam int Q = 4;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2, A_OWN = 2'd3;
  localparam logic [6:0] OWN = 7'h2D;
  localparam logic [7:0] RUN = 8'hC4;   // ien=1 en=1 ack=1

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic scl_m = 1, sda_m = 1;
  logic scl_low, sda_low, irq;
  wire  scl_line = scl_m & ~scl_low;
  wire  sda_line = sda_m & ~sda_low;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  i2cs_slave_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_in(scl_line),
    .sda_in(sda_line), .scl_low(scl_low), .sda_low(sda_low), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [7:0] e, input string req);
    logic [7:0] d;
    rd(a, d);
    chk(d == e, req, d, e);
  endtask

  task automatic scl_up;
    scl_m = 1;
    @(negedge clk);
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bstart;
    sda_m = 1; idle(Q); scl_up(); idle(Q); sda_m = 0; idle(Q); scl_m = 0; idle(Q);
  endtask

  task automatic bstop;
    sda_m = 0; idle(Q); scl_up(); idle(Q); sda_m = 1; idle(Q);
  endtask

  task automatic bbit(input logic b);
    sda_m = b; idle(Q); scl_up(); idle(2*Q); scl_m = 0; idle(Q);
  endtask

  // returns the sampled ninth bit: 0 = acknowledged
  task automatic send_byte(input logic [7:0] b, output logic ackb);
    for (int i = 7; i >= 0; i--) bbit(b[i]);
    sda_m = 1; idle(Q); scl_up(); idle(Q); ackb = sda_line; idle(Q); scl_m = 0; idle(8);
  endtask

  task automatic clr(input logic [7:0] ctrl);
    wr(A_CTRL, ctrl | 8'h08);
  endtask

  task automatic addr_ok;
    logic ackb;
    bstart(); send_byte({OWN, 1'b0}, ackb);
    chk(ackb == 1'b0, "R6 addressing", ackb, 0);
    expect_reg(A_STAT, 8'h60, "R6 status");
    clr(RUN);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic ackb;
    idle(3); rst_n = 1; idle(2);

    // reset state
    expect_reg(A_CTRL, 8'h00, "R1 ctrl reset");
    expect_reg(A_STAT, 8'hF8, "R4 status reset");
    expect_reg(A_DATA, 8'h00, "R1 data reset");
    chk(!irq && !scl_low && !sda_low, "R3 outputs reset", {irq, scl_low, sda_low}, 0);

    wr(A_OWN, {OWN, 1'b1});
    expect_reg(A_OWN, {OWN, 1'b0}, "R1 own address bit0");
    wr(A_CTRL, RUN);
    expect_reg(A_CTRL, RUN, "R1 ctrl readback");

    // address sweep
    for (int a = 0; a < 128; a++) begin
      logic hit;
      hit = (a[6:0] == OWN);
      bstart(); send_byte({a[6:0], 1'b0}, ackb);
      chk(ackb == !hit, "R6 address ack", ackb, !hit);
      expect_reg(A_STAT, hit ? 8'h60 : 8'hF8, "R6 address status");
      if (hit) begin
        chk(scl_low == 1, "R12 stretch after 60h", scl_low, 1);
        chk(irq == 1, "R3 irq with flag", irq, 1);
        expect_reg(A_DATA, {OWN, 1'b0}, "R6 data holds address");
        wr(A_CTRL, RUN);
        expect_reg(A_CTRL, RUN | 8'h08, "R2 write 0 keeps flag");
        clr(RUN);
        bus_addr = A_STAT; #1 d = bus_rdata;
        chk(d == 8'h60, "R5 code one clock after clear", d, 8'h60);
        expect_reg(A_STAT, 8'hF8, "R5 code gone");
        chk(scl_low == 0 && irq == 0, "R12 release on clear", {scl_low, irq}, 0);
        bstop();
        expect_reg(A_STAT, 8'hA0, "R9 stop while addressed");
        chk(scl_low == 0, "R12 no stretch for A0h", scl_low, 0);
        clr(RUN);
      end else bstop();
    end

    // read direction is not accepted
    bstart(); send_byte({OWN, 1'b1}, ackb);
    chk(ackb == 1, "R6 read bit nack", ackb, 1);
    expect_reg(A_STAT, 8'hF8, "R6 read bit no event");
    bstop();

    // data sweep
    addr_ok();
    for (int v = 0; v < 256; v++) begin
      send_byte(v[7:0], ackb);
      chk(ackb == 0, "R7 data ack", ackb, 0);
      expect_reg(A_STAT, 8'h80, "R7 data status");
      expect_reg(A_DATA, v[7:0], "R7 data byte");
      clr(RUN);
    end

    // NACK path
    wr(A_CTRL, RUN & ~8'h04);
    send_byte(8'h3C, ackb);
    chk(ackb == 1, "R8 nack driven", ackb, 1);
    expect_reg(A_STAT, 8'h88, "R8 nack status");
    expect_reg(A_DATA, 8'h3C, "R8 data byte");
    chk(scl_low == 1, "R12 stretch after 88h", scl_low, 1);
    clr(RUN & ~8'h04);
    wr(A_CTRL, RUN);
    send_byte(8'hC3, ackb);
    chk(ackb == 1, "R8 not addressed after nack", ackb, 1);
    expect_reg(A_STAT, 8'hF8, "R8 no event after nack");
    bstop();
    expect_reg(A_STAT, 8'hF8, "R8 stop while idle silent");

    // repeated start
    addr_ok();
    bstart();
    expect_reg(A_STAT, 8'hA0, "R9 repeated start");
    chk(scl_low == 0, "R12 no stretch on restart", scl_low, 0);
    clr(RUN);
    send_byte({OWN, 1'b0}, ackb);
    chk(ackb == 0, "R9 readdress ack", ackb, 0);
    expect_reg(A_STAT, 8'h60, "R9 readdress status");
    clr(RUN);
    send_byte(8'h81, ackb);
    expect_reg(A_DATA, 8'h81, "R9 data after restart");
    clr(RUN);
    bstop();
    clr(RUN);

    // bus error
    addr_ok();
    bbit(1); bbit(0); bbit(1);
    bstart();
    expect_reg(A_STAT, 8'h00, "R10 bus error code");
    expect_reg(A_CTRL, RUN | 8'h08, "R10 flag set");
    chk(scl_low == 0, "R12 no stretch on error", scl_low, 0);
    send_byte({OWN, 1'b0}, ackb);
    chk(ackb == 1, "R10 bus ignored", ackb, 1);
    expect_reg(A_STAT, 8'h00, "R10 code kept");
    wr(A_CTRL, RUN | 8'h10);
    expect_reg(A_CTRL, RUN | 8'h08, "R11 stop bit self clears");
    clr(RUN);
    expect_reg(A_STAT, 8'hF8, "R10 cleared");
    bstop();
    addr_ok();
    send_byte(8'h5E, ackb);
    chk(ackb == 0, "R11 recovered", ackb, 0);
    expect_reg(A_DATA, 8'h5E, "R11 recovered data");
    clr(RUN);

    // stop request while addressed
    wr(A_CTRL, RUN | 8'h10);
    send_byte(8'h77, ackb);
    chk(ackb == 1, "R11 drop out", ackb, 1);
    expect_reg(A_STAT, 8'hF8, "R11 no event after drop");
    bstop();

    // interrupt enable off
    wr(A_CTRL, 8'h44);
    bstart(); send_byte({OWN, 1'b0}, ackb);
    expect_reg(A_STAT, 8'h60, "R3 event with irq off");
    chk(irq == 0, "R3 irq masked", irq, 0);
    clr(8'h44);
    bstop(); clr(8'h44);

    // engine disabled
    wr(A_CTRL, 8'h90);
    expect_reg(A_CTRL, 8'h80, "R11 stop forced 0 when disabled");
    bstart(); send_byte({OWN, 1'b0}, ackb);
    chk(ackb == 1, "R13 disabled nack", ackb, 1);
    expect_reg(A_STAT, 8'hF8, "R13 disabled no event");
    bstop();
    chk(irq == 0, "R13 no irq", irq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule